// File: doc/BRIEF.md
# Byte-Lane Static Memory with Pin-Style Control

This block is a single-port word memory driven by active-low control inputs: a chip select, a write strobe, an output enable and one enable per byte lane. A write stores only the byte lanes whose enable is low. A read returns the addressed word on a data-out bus. Beside that bus sits a per-lane drive-enable vector that stands in for tri-state pins: a lane is "driven" only when its drive-enable bit is high, and an undriven lane reads as zero. All controls are sampled on the rising clock edge. Read data, drive enables and status flags are registered and change on the edge that samples the controls.

Two status flags come from the control pins. The standby flag shows that the part is deselected, either because the chip select is high or because both lane enables are high. The power-down flag shows that the part is selected but its address has not moved for a set number of clocks. A small power-state machine produces both flags. It has three states. PS_STANDBY means deselected. PS_ACTIVE means selected with a recently changed address. PS_POWERDOWN means selected with the address idle. The transitions are as follows. Any state goes to PS_STANDBY when the part is deselected at an edge. PS_STANDBY goes to PS_ACTIVE when the part is selected again. PS_ACTIVE goes to PS_POWERDOWN when the address has matched its previous value on IDLE_CYCLES consecutive edges. PS_POWERDOWN goes to PS_ACTIVE on the first edge with a new address. Otherwise each state holds. IDLE_CYCLES must be at least 2.

The depth is 2^ADDR_W words of 2 x LANE_W bits. ADDR_W = 16 and LANE_W = 8 give the 64K x 16 organisation. The default ADDR_W is kept small so that a default build stays light.

Top module: `bytelane_sram`

## Requirements
- R1: The memory holds 2^ADDR_W words of 2*LANE_W bits. A write happens at a rising edge where ce_n = 0 and we_n = 0, and it addresses the word selected by addr.
- R2: During a write, ble_n = 0 stores din[LANE_W-1:0] and bhe_n = 0 stores din[2*LANE_W-1:LANE_W]. A lane whose enable is 1 keeps its old contents.
- R3: A read happens at an edge where ce_n = 0, oe_n = 0 and we_n = 1. After that edge, drive_en[0] = !ble_n and drive_en[1] = !bhe_n, and each driven lane of dout carries the stored byte.
- R4: A dout lane whose drive_en bit is 0 reads as all zeros.
- R5: drive_en is 2'b00 after any edge that samples ce_n = 1, or oe_n = 1, or ble_n = bhe_n = 1.
- R6: A write takes priority over output enable. With ce_n = 0 and we_n = 0 the cycle is a write whatever oe_n is, and drive_en is 2'b00 after that edge.
- R7: After each edge, standby = 1 exactly when the edge sampled ce_n = 1 or ble_n = bhe_n = 1.
- R8: pwr_down rises after IDLE_CYCLES consecutive selected edges at which addr equals its value at the previous edge. It falls on the first edge with a different addr, and it is 0 whenever standby is 1.
- R9: A read of an address that was just written returns the new bytes in the written lanes and the earlier bytes in the other lanes.
- R10: While rst_n = 0: drive_en = 0, dout = 0, standby = 1, pwr_down = 0. The state machine is in PS_STANDBY, and the held previous address is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| ble_n | input | 1 | Low byte lane enable, active low |
| bhe_n | input | 1 | High byte lane enable, active low |
| addr | input | ADDR_W | Word address |
| din | input | 2*LANE_W | Write data |
| dout | output | 2*LANE_W | Read data, undriven lanes zero |
| drive_en | output | 2 | Per-lane output drive enable (bit 0 low lane) |
| standby | output | 1 | Deselected status |
| pwr_down | output | 1 | Idle-address power-down status |

## Verification
The bench builds the block with ADDR_W = 8, LANE_W = 8 and IDLE_CYCLES = 4. A 256-word array can be filled completely in a few hundred cycles, so every later read compares against a fully known reference, and random addresses collide often enough to exercise write-then-read at the same word. An idle threshold of 4 lets the power-down entry, the exit on an address change and the forced clear in standby all happen many times in a short run. The sweep also covers all 32 combinations of the five control pins.

// File: rtl/bls_pkg.sv
package bls_pkg;

    typedef enum logic [1:0] {
        PS_STANDBY   = 2'd0,
        PS_ACTIVE    = 2'd1,
        PS_POWERDOWN = 2'd2
    } pwr_state_t;

endpackage

// File: rtl/bls_lane_array.sv
module bls_lane_array #(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 8,
    parameter int LANES  = 2
) (
    input  logic                    clk,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] din,
    input  logic [LANES-1:0]        wr_lane,
    output logic [LANES*LANE_W-1:0] rd_word
);
    localparam int WORDS = 1 << ADDR_W;

    // One storage column per byte lane; each lane writes on its own strobe.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] store [WORDS];
        logic [LANE_W-1:0] rd_q;

        always_ff @(posedge clk) begin
            if (wr_lane[g]) begin
                store[addr] <= din[g*LANE_W +: LANE_W];
            end
            rd_q <= store[addr];
        end

        assign rd_word[g*LANE_W +: LANE_W] = rd_q;
    end

endmodule

// File: rtl/bls_io_ctrl.sv
module bls_io_ctrl #(
    parameter int LANE_W = 8,
    parameter int LANES  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ce_n,
    input  logic                    we_n,
    input  logic                    oe_n,
    input  logic [LANES-1:0]        lane_sel,
    input  logic [LANES*LANE_W-1:0] rd_word,
    output logic [LANES-1:0]        wr_lane,
    output logic [LANES-1:0]        drive_en,
    output logic [LANES*LANE_W-1:0] dout
);
    logic wr_cycle;
    logic rd_cycle;

    // Write strobe wins over output enable.
    assign wr_cycle = !ce_n && !we_n;
    assign rd_cycle = !ce_n && we_n && !oe_n;
    assign wr_lane  = wr_cycle ? lane_sel : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drive_en <= '0;
        end else begin
            drive_en <= rd_cycle ? lane_sel : '0;
        end
    end

    // Undriven lanes are presented as zero.
    for (genvar g = 0; g < LANES; g++) begin : g_out
        assign dout[g*LANE_W +: LANE_W] = drive_en[g] ? rd_word[g*LANE_W +: LANE_W]
                                                      : '0;
    end

    AST_WRITE_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !we_n) |=> (drive_en == '0)); // R6
    AST_OE_HIGH_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_n || ce_n) |=> (drive_en == '0)); // R5
    AST_LOW_LANE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !drive_en[0] |-> (dout[LANE_W-1:0] == '0)); // R4

endmodule

// File: rtl/bls_power_fsm.sv
module bls_power_fsm
    import bls_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int LANES       = 2,
    parameter int IDLE_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic [LANES-1:0]  lane_sel,
    input  logic [ADDR_W-1:0] addr,
    output logic              standby,
    output logic              pwr_down
);
    localparam int CNT_W = $clog2(IDLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST_IDLE = CNT_W'(IDLE_CYCLES - 1);

    pwr_state_t        state, nxt_state;
    logic [ADDR_W-1:0] prev_addr;
    logic [CNT_W-1:0]  idle_cnt, idle_cnt_nxt;
    logic              desel;
    logic              addr_same;

    assign desel     = ce_n || (lane_sel == '0);
    assign addr_same = (addr == prev_addr);

    // State register, idle counter and previous address.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= PS_STANDBY;
            prev_addr <= '0;
            idle_cnt  <= '0;
        end else begin
            state     <= nxt_state;
            prev_addr <= addr;
            idle_cnt  <= idle_cnt_nxt;
        end
    end

    // Next state and counter.
    always_comb begin
        nxt_state    = state;
        idle_cnt_nxt = idle_cnt;
        unique case (state)
            PS_STANDBY: begin
                idle_cnt_nxt = '0;
                if (!desel) begin
                    nxt_state    = PS_ACTIVE;
                    idle_cnt_nxt = addr_same ? CNT_W'(1) : '0;
                end
            end
            PS_ACTIVE: begin
                if (desel) begin
                    nxt_state    = PS_STANDBY;
                    idle_cnt_nxt = '0;
                end else if (!addr_same) begin
                    idle_cnt_nxt = '0;
                end else if (idle_cnt == LAST_IDLE) begin
                    nxt_state    = PS_POWERDOWN;
                end else begin
                    idle_cnt_nxt = idle_cnt + CNT_W'(1);
                end
            end
            PS_POWERDOWN: begin
                if (desel) begin
                    nxt_state    = PS_STANDBY;
                    idle_cnt_nxt = '0;
                end else if (!addr_same) begin
                    nxt_state    = PS_ACTIVE;
                    idle_cnt_nxt = '0;
                end
            end
            default: begin
                nxt_state    = PS_STANDBY;
                idle_cnt_nxt = '0;
            end
        endcase
    end

    // Outputs decoded from the state.
    always_comb begin
        standby  = 1'b0;
        pwr_down = 1'b0;
        unique case (state)
            PS_STANDBY:   standby  = 1'b1;
            PS_ACTIVE:    ;
            PS_POWERDOWN: pwr_down = 1'b1;
            default:      standby  = 1'b1;
        endcase
    end

    AST_PD_CLEARS_ON_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_down && (addr != prev_addr)) |=> !pwr_down); // R8
    AST_DESEL_TO_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> (standby && !pwr_down)); // R7
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        idle_cnt <= LAST_IDLE); // R8

endmodule

// File: rtl/bytelane_sram.sv
module bytelane_sram #(
    parameter int ADDR_W      = 10,
    parameter int LANE_W      = 8,
    parameter int IDLE_CYCLES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ce_n,
    input  logic                  we_n,
    input  logic                  oe_n,
    input  logic                  ble_n,
    input  logic                  bhe_n,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [2*LANE_W-1:0]   din,
    output logic [2*LANE_W-1:0]   dout,
    output logic [1:0]            drive_en,
    output logic                  standby,
    output logic                  pwr_down
);
    localparam int LANES = 2;

    logic [LANES-1:0]        lane_sel;
    logic [LANES-1:0]        wr_lane;
    logic [LANES*LANE_W-1:0] rd_word;

    assign lane_sel = {!bhe_n, !ble_n};

    bls_lane_array #(
        .ADDR_W (ADDR_W),
        .LANE_W (LANE_W),
        .LANES  (LANES)
    ) u_array (
        .clk     (clk),
        .addr    (addr),
        .din     (din),
        .wr_lane (wr_lane),
        .rd_word (rd_word)
    );

    bls_io_ctrl #(
        .LANE_W (LANE_W),
        .LANES  (LANES)
    ) u_io (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (ce_n),
        .we_n     (we_n),
        .oe_n     (oe_n),
        .lane_sel (lane_sel),
        .rd_word  (rd_word),
        .wr_lane  (wr_lane),
        .drive_en (drive_en),
        .dout     (dout)
    );

    bls_power_fsm #(
        .ADDR_W      (ADDR_W),
        .LANES       (LANES),
        .IDLE_CYCLES (IDLE_CYCLES)
    ) u_pwr (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (ce_n),
        .lane_sel (lane_sel),
        .addr     (addr),
        .standby  (standby),
        .pwr_down (pwr_down)
    );

    AST_DRIVE_NOT_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_en != 2'b00) |-> !standby); // R7
    AST_PD_NOT_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
        !(pwr_down && standby)); // R8

endmodule

// File: tb/bytelane_sram_tb.sv
module bytelane_sram_tb;
    localparam int AW    = 8;
    localparam int LW    = 8;
    localparam int IDLE  = 4;
    localparam int WORDS = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, ble_n = 1'b1, bhe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [15:0]   din = '0;
    logic [15:0]   dout;
    logic [1:0]    drive_en;
    logic          standby, pwr_down;

    int n_tests = 0;
    int n_fail  = 0;
    bit cmp_on  = 1'b0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    bytelane_sram #(.ADDR_W(AW), .LANE_W(LW), .IDLE_CYCLES(IDLE)) u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .ble_n(ble_n), .bhe_n(bhe_n), .addr(addr), .din(din),
        .dout(dout), .drive_en(drive_en), .standby(standby), .pwr_down(pwr_down)
    );

    // Behavioural reference
    logic [15:0] ref_mem [WORDS];
    logic [15:0] exp_dout = '0;
    logic [1:0]  exp_drive = '0;
    logic        exp_stby = 1'b1;
    logic        exp_pd = 1'b0;
    int          idle_run = 0;
    logic [AW-1:0] ref_prev = '0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_dout = '0; exp_drive = '0; exp_stby = 1'b1; exp_pd = 1'b0;
            idle_run = 0; ref_prev = '0;
        end else begin
            bit rd, wr, desel;
            logic [15:0] w;
            rd    = !ce_n && we_n && !oe_n;
            wr    = !ce_n && !we_n;
            desel = ce_n || (ble_n && bhe_n);
            w     = ref_mem[addr];
            exp_drive = rd ? {!bhe_n, !ble_n} : 2'b00;
            exp_dout  = {exp_drive[1] ? w[15:8] : 8'h00, exp_drive[0] ? w[7:0] : 8'h00};
            if (wr) begin
                if (!ble_n) w[7:0]  = din[7:0];
                if (!bhe_n) w[15:8] = din[15:8];
                ref_mem[addr] = w;
            end
            exp_stby = desel;
            if (desel || addr != ref_prev) idle_run = 0;
            else idle_run = idle_run + 1;
            exp_pd   = !desel && (idle_run >= IDLE);
            ref_prev = addr;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R3 R4 R9 dout", 32'(dout), 32'(exp_dout));
            chk("R5 R6 drive_en", 32'(drive_en), 32'(exp_drive));
            chk("R7 standby", 32'(standby), 32'(exp_stby));
            chk("R8 pwr_down", 32'(pwr_down), 32'(exp_pd));
        end
    end

    task automatic drv(input logic c, input logic w, input logic o, input logic bl,
                       input logic bh, input logic [AW-1:0] a, input logic [15:0] d);
        ce_n = c; we_n = w; oe_n = o; ble_n = bl; bhe_n = bh; addr = a; din = d;
        @(negedge clk);
    endtask

    function automatic logic [15:0] pat(input int a);
        return 16'((a * 16'h0101) ^ 16'h5A3C);
    endfunction

    initial begin
        repeat (2) @(negedge clk);
        // R10: reset state
        chk("R10 dout", 32'(dout), 32'h0);
        chk("R10 drive_en", 32'(drive_en), 32'h0);
        chk("R10 standby", 32'(standby), 32'h1);
        chk("R10 pwr_down", 32'(pwr_down), 32'h0);
        cmp_on = 1'b1;
        rst_n  = 1'b1;
        @(negedge clk);

        // R1: fill every word with full-width writes
        for (int a = 0; a < WORDS; a++) drv(0, 0, 1, 0, 0, AW'(a), pat(a));
        drv(0, 1, 0, 0, 0, AW'(WORDS - 1), 16'h0);
        chk("R1 last word", 32'(dout), 32'(pat(WORDS - 1)));

        // R2/R9: low-lane-only write then read back
        drv(0, 0, 1, 0, 1, 8'd7, 16'hBEEF);
        drv(0, 1, 0, 0, 0, 8'd7, 16'h0);
        chk("R2 R9 low lane write", 32'(dout), 32'({pat(7) >> 8, 8'hEF}) & 32'hFFFF);
        drv(0, 0, 1, 1, 0, 8'd7, 16'h1234);
        drv(0, 1, 0, 0, 0, 8'd7, 16'h0);
        chk("R2 R9 high lane write", 32'(dout), 32'h12EF);

        // R3/R4: read with only the high lane enabled
        drv(0, 1, 0, 1, 0, 8'd7, 16'h0);
        chk("R3 R4 high lane only", 32'(dout), 32'h1200);
        chk("R3 drive_en high only", 32'(drive_en), 32'h2);

        // R6: write with output enable also low drives nothing
        drv(0, 0, 0, 0, 0, 8'd9, 16'hC0DE);
        chk("R6 write priority", 32'(drive_en), 32'h0);
        drv(0, 1, 0, 0, 0, 8'd9, 16'h0);
        chk("R6 write landed", 32'(dout), 32'hC0DE);

        // R5: every control combination
        for (int c = 0; c < 32; c++) begin
            logic [4:0] v;
            v = 5'(c);
            drv(v[4], v[3], v[2], v[1], v[0], AW'(c * 7), 16'(c * 16'h1111) ^ 16'h0F0F);
        end

        // R8: idle address in read, exit by change, forced clear by deselect
        for (int i = 0; i < 7; i++) drv(0, 1, 0, 0, 0, 8'd20, 16'h0);
        chk("R8 pd set after idle", 32'(pwr_down), 32'h1);
        drv(0, 1, 0, 0, 0, 8'd21, 16'h0);
        chk("R8 pd clear on move", 32'(pwr_down), 32'h0);
        for (int i = 0; i < 6; i++) drv(0, 1, 1, 0, 1, 8'd21, 16'h0);
        drv(1, 1, 1, 0, 1, 8'd21, 16'h0);
        chk("R8 pd low in standby", 32'(pwr_down), 32'h0);
        chk("R7 standby on ce_n", 32'(standby), 32'h1);
        drv(0, 1, 1, 1, 1, 8'd21, 16'h0);
        chk("R7 standby on lanes off", 32'(standby), 32'h1);

        // Mixed random traffic with a sticky address
        begin
            logic [AW-1:0] a;
            a = 8'd3;
            for (int i = 0; i < 4000; i++) begin
                logic [31:0] r;
                r = $urandom;
                if (r[2:0] == 3'd0) a = AW'($urandom);
                drv((r[7:4] == 4'd0), r[8], r[9], r[10], r[11], a, 16'($urandom));
            end
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule